// File: doc/BRIEF.md
# Port-Driven Sound Generator Register Bridge

This block sits behind a general-purpose parallel port and turns software pin toggling into register cycles for a programmable sound generator. Software first loads a value into the port B output register. It then writes port A. The two lowest port A bits carry a bus operation code. On the clock in which port A is written, the block acts on that code once. It may latch port B as the register address, store port B into the addressed register, or copy the addressed register onto a read-back bus. Leaving the pins unchanged afterwards never repeats the access.

A bank of sixteen 8-bit registers stands in for the sound generator's register side. One register of the bank is the generator's general-purpose output port, and its value is driven out continuously. A third port A bit pages between a boot ROM and a BASIC ROM. That bit only takes effect while its direction bit marks the pin as an output. When the pin is an input, a pull-up holds it high, so the boot ROM is selected.

Top module: `psg_port_bridge`

## Requirements
- R1: After reset every bank register, the output port `psg_io`, the read-back bus `pb_in` and the latched address are all zero.
- R2: Operation code 00 (pa_out[1:0]) leaves the address, the bank and `pb_in` unchanged, even while `pa_wr` is high.
- R3: Operation code 01 stores `pb_out` into the register selected by the latched address. The stored value shows on the next clock edge.
- R4: Operation code 11 latches `pb_out` as the register address on the clock edge where `pa_wr` is high.
- R5: Operation code 10 copies the selected register onto `pb_in` on the clock edge where `pa_wr` is high. `pb_in` then holds that value until the next read.
- R6: Register 14 is the output port, and its content is driven on `psg_io` at all times.
- R7: When the latched address has any of bits 7..4 set, code 01 changes no register and code 10 returns 8'hFF.
- R8: While pa_ddr[2] is 1, `rom_boot_sel` equals pa_out[2], where 1 selects the boot ROM and 0 selects BASIC.
- R9: While pa_ddr[2] is 0, `rom_boot_sel` is 1 whatever pa_out[2] holds.
- R10: Bits 7..3 of `pa_out` have no effect on which operation is performed.
- R11: An operation happens only on a clock with `pa_wr` high. Port values that stay or change without a strobe cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pa_out | input | 8 | Port A output register value (bits 1..0 operation code, bit 2 ROM page) |
| pa_ddr | input | 8 | Port A direction register, 1 marks an output pin |
| pa_wr | input | 1 | One-cycle strobe for a write to port A |
| pb_out | input | 8 | Port B output register value (address or data) |
| pb_in | output | 8 | Read-back data presented to port B input |
| psg_io | output | 8 | Sound generator output-port register (register 14) |
| rom_boot_sel | output | 1 | 1 selects the boot ROM, 0 selects the BASIC ROM |

## Verification
On every cycle, the assertions check several rules. An address latch must capture port B. Without a strobe, address, read-back data and output port must stay still. A write to register 14 must reach the output port on the next edge, and a write to a high address must leave it alone. A read of a high address must return all ones. An input-direction ROM pin must select the boot ROM. Only the bench scenarios can show the rest. These are register contents kept across many unrelated accesses, reads that return what earlier writes stored, the effect of ignored port A bits, and strobe-less port changes. The bench checks them against a model of the bank.

// File: rtl/psg_bridge_pkg.sv
package psg_bridge_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ADDR  = 2'b11
  } bus_op_e;
endpackage

// File: rtl/psg_op_decode.sv
module psg_op_decode
  import psg_bridge_pkg::*;
(
  input  logic       strobe,
  input  logic [1:0] code,
  output logic       do_write,
  output logic       do_read,
  output logic       do_latch
);
  bus_op_e op;

  always_comb begin
    op       = bus_op_e'(code);
    do_write = 1'b0;
    do_read  = 1'b0;
    do_latch = 1'b0;
    if (strobe) begin
      case (op)
        OP_WRITE: do_write = 1'b1;
        OP_READ:  do_read  = 1'b1;
        OP_ADDR:  do_latch = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int IO_REG   = 14,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] io_port
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic              en_i;
    logic [DATA_W-1:0] d_i;
    always_comb begin
      en_i = wr_en && (wr_idx == IDX_W'(i));
      d_i  = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs_q[i] <= '0;
      else if (en_i) regs_q[i] <= d_i;
    end
  end

  always_comb begin
    rd_val  = regs_q[rd_idx];
    io_port = regs_q[IO_REG];
  end

  // R6: a write to the output-port register reaches io_port on the next edge
  assert_io_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(IO_REG)) |=> io_port == $past(wr_data));

  // R11: without a write enable the output port holds
  assert_io_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(io_port));
endmodule

// File: rtl/psg_rom_select.sv
module psg_rom_select #(
  parameter int DATA_W  = 8,
  parameter int ROM_BIT = 2
) (
  input  logic [DATA_W-1:0] pa_val,
  input  logic [DATA_W-1:0] pa_dir,
  output logic              boot_sel
);
  logic pin_is_out;

  always_comb begin
    pin_is_out = pa_dir[ROM_BIT];
    boot_sel   = pin_is_out ? pa_val[ROM_BIT] : 1'b1;
  end

  // R9: an input-configured page pin always selects the boot ROM
  always_comb begin
    if (!pa_dir[ROM_BIT]) assert_pullup_boot_R9: assert (boot_sel == 1'b1);
  end
endmodule

// File: rtl/psg_port_bridge.sv
module psg_port_bridge
  import psg_bridge_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int IO_REG   = 14,
  parameter int ROM_BIT  = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pa_out,
  input  logic [DATA_W-1:0] pa_ddr,
  input  logic              pa_wr,
  input  logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] psg_io,
  output logic              rom_boot_sel
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic do_write, do_read, do_latch;

  psg_op_decode u_dec (
    .strobe   (pa_wr),
    .code     (pa_out[1:0]),
    .do_write (do_write),
    .do_read  (do_read),
    .do_latch (do_latch)
  );

  logic [DATA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              addr_ok;
  logic [DATA_W-1:0] bank_val;

  always_comb begin
    addr_ok = (addr_q[DATA_W-1:IDX_W] == '0);
    addr_d  = do_latch ? pb_out : addr_q;
    rdat_d  = rdat_q;
    if (do_read) rdat_d = addr_ok ? bank_val : '1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      rdat_q <= '0;
    end else begin
      if (do_latch) addr_q <= addr_d;
      if (do_read)  rdat_q <= rdat_d;
    end
  end

  psg_reg_bank #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IO_REG   (IO_REG)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (do_write && addr_ok),
    .wr_idx  (addr_q[IDX_W-1:0]),
    .wr_data (pb_out),
    .rd_idx  (addr_q[IDX_W-1:0]),
    .rd_val  (bank_val),
    .io_port (psg_io)
  );

  psg_rom_select #(
    .DATA_W  (DATA_W),
    .ROM_BIT (ROM_BIT)
  ) u_rom (
    .pa_val   (pa_out),
    .pa_dir   (pa_ddr),
    .boot_sel (rom_boot_sel)
  );

  assign pb_in = rdat_q;

  // R4: address latch captures port B
  assert_addr_latch_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pa_wr && pa_out[1:0] == 2'b11) |=> addr_q == $past(pb_out));

  // R11: no strobe, no change of address or read-back data
  assert_no_strobe_hold_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pa_wr |=> ($stable(addr_q) && $stable(pb_in)));

  // R7: reads of a high address return all ones
  assert_oob_read_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pa_wr && pa_out[1:0] == 2'b10 && addr_q[DATA_W-1:IDX_W] != '0) |=> pb_in == '1);

  // R7: writes to a high address leave the output port unchanged
  assert_oob_write_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pa_wr && pa_out[1:0] == 2'b01 && addr_q[DATA_W-1:IDX_W] != '0) |=> $stable(psg_io));

  // R2: the idle code changes nothing
  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pa_wr && pa_out[1:0] == 2'b00) |=> ($stable(addr_q) && $stable(pb_in) && $stable(psg_io)));
endmodule

// File: tb/sim_psg_port_bridge.sv
module sim_psg_port_bridge;
  logic       clk;
  logic       rst_n;
  logic [7:0] pa_out, pa_ddr, pb_out;
  logic       pa_wr;
  logic [7:0] pb_in, psg_io;
  logic       rom_boot_sel;

  int checks;
  int errors;
  bit done;

  logic [7:0] mdl [16];
  logic [7:0] mdl_addr;
  logic [7:0] mdl_rd;

  psg_port_bridge u0 (
    .clk (clk), .rst_n (rst_n), .pa_out (pa_out), .pa_ddr (pa_ddr),
    .pa_wr (pa_wr), .pb_out (pb_out), .pb_in (pb_in), .psg_io (psg_io),
    .rom_boot_sel (rom_boot_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic exp_rom(input logic [7:0] pa, input logic [7:0] ddr);
    return ddr[2] ? pa[2] : 1'b1;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    return (a[7:4] != 4'h0) ? 8'hFF : mdl[a[3:0]];
  endfunction

  // model update for one strobed port A write
  task automatic model_op(input logic [7:0] pa, input logic [7:0] pb);
    case (pa[1:0])
      2'b11: mdl_addr = pb;
      2'b01: if (mdl_addr[7:4] == 4'h0) mdl[mdl_addr[3:0]] = pb;
      2'b10: mdl_rd = exp_read(mdl_addr);
      default: ;
    endcase
  endtask

  // drive on falling edge, strobe for one rising edge, check on next falling edge
  task automatic port_op(input logic [7:0] pa, input logic [7:0] pb, input string req);
    @(negedge clk);
    pa_out = pa; pb_out = pb; pa_wr = 1'b1;
    model_op(pa, pb);
    @(negedge clk);
    pa_wr = 1'b0;
    chk(req, pb_in, mdl_rd);
    chk(req, psg_io, mdl[14]);
    chk(req, {7'd0, rom_boot_sel}, {7'd0, exp_rom(pa_out, pa_ddr)});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    mdl_addr = 8'h00; mdl_rd = 8'h00;
    pa_out = 8'h00; pa_ddr = 8'h00; pb_out = 8'h00; pa_wr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1", psg_io, 8'h00);
    chk("R1", pb_in, 8'h00);
    port_op(8'h02, 8'h00, "R1"); // read reg 0 through reset address 0

    // R4 R3 R6: latch 14, write, output port follows
    port_op(8'h03, 8'h0E, "R4");
    port_op(8'h01, 8'hA5, "R6");
    port_op(8'h02, 8'h00, "R5");
    chk("R5", pb_in, 8'hA5);

    // R3: other register, read back
    port_op(8'h03, 8'h05, "R4");
    port_op(8'h01, 8'h3C, "R3");
    port_op(8'h02, 8'h77, "R3");
    chk("R3", pb_in, 8'h3C);

    // R7: high address
    port_op(8'h03, 8'h3E, "R7");
    port_op(8'h01, 8'h11, "R7");
    chk("R7", psg_io, 8'hA5);
    port_op(8'h02, 8'h00, "R7");
    chk("R7", pb_in, 8'hFF);

    // R2: idle code with strobe
    port_op(8'h00, 8'h0E, "R2");
    port_op(8'h01, 8'h22, "R2"); // still high address, blocked
    chk("R2", psg_io, 8'hA5);

    // R10: upper bits set, code 11 then 01
    port_op(8'hF8 | 8'h03, 8'h0E, "R10");
    port_op(8'hF8 | 8'h01, 8'h5A, "R10");
    chk("R10", psg_io, 8'h5A);

    // R11: static write code, pb changes, no strobe
    @(negedge clk);
    pa_out = 8'h01; pb_out = 8'hC3;
    repeat (4) @(negedge clk);
    chk("R11", psg_io, 8'h5A);
    pa_out = 8'h02;
    repeat (2) @(negedge clk);
    chk("R11", pb_in, mdl_rd);

    // R8 R9: ROM page select
    pa_ddr = 8'h04; pa_out = 8'h04; #1;
    chk("R8", {7'd0, rom_boot_sel}, 8'h01);
    pa_out = 8'h00; #1;
    chk("R8", {7'd0, rom_boot_sel}, 8'h00);
    pa_ddr = 8'hFB; #1;
    chk("R9", {7'd0, rom_boot_sel}, 8'h01);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] pa, pb;
      pa = 8'($urandom);
      pb = 8'($urandom);
      if (pa[1:0] == 2'b11 && ($urandom % 4) != 0) pb[7:4] = 4'h0;
      pa_ddr = 8'($urandom);
      port_op(pa, pb, pa[1:0] == 2'b01 ? "R3" : pa[1:0] == 2'b10 ? "R5" :
                      pa[1:0] == 2'b11 ? "R4" : "R2");
    end

    // final sweep of the bank through reads
    for (int r = 0; r < 16; r++) begin
      port_op(8'h03, 8'(r), "R4");
      port_op(8'h02, 8'h00, "R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule